// File: doc/BRIEF.md
# Address-Latched One-Time-Programmable ROM

This block is a behavioural, synthesizable model of a byte-wide one-time-programmable memory. It has its own address latch, so a host with a multiplexed address/data bus can connect without an external latch. While the address strobe is high, the applied address passes straight through to the array. While the strobe is low, the address last seen with the strobe high is held. Two active-low enables, a program-voltage flag and a signature-mode flag together select one of seven modes: read, output disable, standby, program, verify, program inhibit and identifier readout.

Every word starts erased, with all bits at one. A program pulse can only clear bits, so the stored word becomes the old word ANDed with the supplied data. In place of a bidirectional pin there are separate data-in and data-out ports and an output-enable flag. When the flag is low, data-out is forced to zero. The array holds 2**ADDR_W words of DATA_W bits. The default is a reduced 1024-word array, and ADDR_W = 15 gives the full 32K x 8 part. All control inputs are sampled on `clk`, and the outputs follow the inputs and the array combinationally.

Top module: `otp_latched_rom`

## Requirements
- R1: After reset every word reads as all ones (0xFF for DATA_W = 8).
- R2: While addrStrobe is 1, the effective address equals addrIn. While addrStrobe is 0, the effective address is the addrIn value sampled at the last clock edge with addrStrobe at 1, and later changes on addrIn are ignored.
- R3: Read: with chipEnN = 0, outEnN = 0, progVolt = 0 and sigMode = 0, dataOutEn = 1 and dataOut equals the word at the effective address.
- R4: Output disable: with chipEnN = 0, outEnN = 1 and progVolt = 0, dataOutEn = 0 and dataOut = 0.
- R5: Standby: with chipEnN = 1 and progVolt = 0, dataOutEn = 0 whatever the value of outEnN.
- R6: Program: with progVolt = 1 and outEnN = 1, one or more cycles with chipEnN = 0 followed by a cycle with chipEnN = 1 (and progVolt still 1) commit at the end of that cycle. The word at the effective address of the last low cycle becomes the old word AND the dataIn of that cycle, and the new word is readable from the next cycle. No bit ever changes from 0 to 1.
- R7: Verify: with progVolt = 1, outEnN = 0 and chipEnN = 1, dataOutEn = 1 and dataOut equals the stored word.
- R8: With progVolt = 1 and both enables at 1 (program inhibit), or with progVolt = 1 and both enables at 0, dataOutEn = 0. A rising chipEnN that does not follow a program cycle writes nothing.
- R9: Identifier readout: with sigMode = 1, chipEnN = 0, outEnN = 0 and progVolt = 0, dataOut is 0x20 when addrIn[0] = 0 and 0x80 when addrIn[0] = 1. The applied addrIn is used directly, whatever the strobe.
- R10: If progVolt is 0 in the cycle where chipEnN rises after a program pulse, nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; erases the array |
| chipEnN | input | 1 | Chip enable, active low |
| outEnN | input | 1 | Output enable, active low |
| progVolt | input | 1 | Program-voltage present flag |
| sigMode | input | 1 | Identifier readout select |
| addrStrobe | input | 1 | Address latch transparent while high |
| addrIn | input | ADDR_W | Applied address |
| dataIn | input | DATA_W | Program data |
| dataOut | output | DATA_W | Read data, zero when not driven |
| dataOutEn | output | 1 | Data-out drive enable |

## Verification
A program commit and a verify read can fall in the same cycle. This happens when the pulse that ends a program operation raises chipEnN and lowers outEnN on the same clock. The bench provokes this overlap and expects the old word during the commit cycle, because the array is written at the edge that closes that cycle. It then expects the ANDed word in the next cycle. A second overlap puts a latch update in the same cycle as a program capture: the address strobe goes low while chipEnN is low, and the bench checks that the held address, not the applied one, receives the write.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_READ,
    MODE_OUTDIS,
    MODE_PROG,
    MODE_VERIFY,
    MODE_INHIBIT,
    MODE_SIGNATURE
  } otpMode_t;

  typedef struct packed {
    logic latchOpen;
    logic capture;
    logic commit;
    logic driveOut;
    logic useSig;
  } ctrlStrobes_t;

endpackage

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         chipEnN,
  input  logic         outEnN,
  input  logic         progVolt,
  input  logic         sigMode,
  input  logic         addrStrobe,
  output ctrlStrobes_t strb
);

  otpMode_t mode;
  logic     prevProg;

  // Mode decode: the program-voltage flag splits the table in two halves
  always_comb begin
    if (!progVolt) begin
      if (chipEnN)      mode = MODE_STANDBY;
      else if (outEnN)  mode = MODE_OUTDIS;
      else if (sigMode) mode = MODE_SIGNATURE;
      else              mode = MODE_READ;
    end else begin
      unique case ({chipEnN, outEnN})
        2'b01:   mode = MODE_PROG;
        2'b10:   mode = MODE_VERIFY;
        2'b11:   mode = MODE_INHIBIT;
        default: mode = MODE_OUTDIS;  // both enables low: no drive, no write
      endcase
    end
  end

  // Remember that the previous cycle was inside a program pulse
  always_ff @(posedge clk) begin
    if (rst) prevProg <= 1'b0;
    else     prevProg <= (mode == MODE_PROG);
  end

  always_comb begin
    strb.latchOpen = addrStrobe;
    strb.capture   = (mode == MODE_PROG);
    strb.commit    = prevProg && chipEnN && progVolt;
    strb.driveOut  = (mode == MODE_READ) || (mode == MODE_VERIFY) ||
                     (mode == MODE_SIGNATURE);
    strb.useSig    = (mode == MODE_SIGNATURE);
  end

  // Standby keeps the outputs off regardless of outEnN
  assert_standby_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!progVolt && chipEnN) |-> !strb.driveOut);

  // A program capture never coincides with driving the outputs
  assert_no_drive_while_prog_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.driveOut, strb.capture}));

  // With the program flag on, both enables high or both low never drive
  assert_inhibit_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (progVolt && (chipEnN == outEnN)) |-> !strb.driveOut);

endmodule

// File: rtl/otp_datapath.sv
module otp_datapath
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] ID_EVEN = 'h20,
  parameter logic [DATA_W-1:0] ID_ODD  = 'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] heldAddr;
  logic [ADDR_W-1:0] effAddr;
  logic [ADDR_W-1:0] pgmAddr;
  logic [DATA_W-1:0] pgmData;
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] idWord;

  // Address latch: follows addrIn while open, holds otherwise
  always_ff @(posedge clk) begin
    if (rst)                 heldAddr <= '0;
    else if (strb.latchOpen) heldAddr <= addrIn;
  end

  assign effAddr = strb.latchOpen ? addrIn : heldAddr;

  // Program capture during the low pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      pgmAddr <= '0;
      pgmData <= '1;
    end else if (strb.capture) begin
      pgmAddr <= effAddr;
      pgmData <= dataIn;
    end
  end

  // Array: erased to ones on reset, bits only cleared by a commit
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '1;
    end else if (strb.commit) begin
      mem[pgmAddr] <= mem[pgmAddr] & pgmData;
    end
  end

  assign rdWord    = mem[effAddr];
  assign idWord    = addrIn[0] ? ID_ODD : ID_EVEN;
  assign dataOutEn = strb.driveOut;
  assign dataOut   = !strb.driveOut ? '0 : (strb.useSig ? idWord : rdWord);

  // A closed latch keeps the effective address steady
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!strb.latchOpen && $past(!strb.latchOpen)) |-> (effAddr == $past(effAddr)));

  // No stored bit ever goes from 0 back to 1
  assert_bits_only_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $stable(effAddr) |-> ((rdWord & ~$past(rdWord)) == '0));

  // Without a commit in the previous cycle the addressed word is unchanged
  assert_write_needs_commit_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(strb.commit) && $stable(effAddr)) |-> $stable(rdWord));

  // Identifier readout only ever shows one of the two codes
  assert_id_codes_R9: assert property (@(posedge clk) disable iff (rst)
    (strb.driveOut && strb.useSig) |-> (dataOut == ID_EVEN || dataOut == ID_ODD));

endmodule

// File: rtl/otp_latched_rom.sv
module otp_latched_rom
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progVolt,
  input  logic              sigMode,
  input  logic              addrStrobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  ctrlStrobes_t strb;

  otp_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .chipEnN    (chipEnN),
    .outEnN     (outEnN),
    .progVolt   (progVolt),
    .sigMode    (sigMode),
    .addrStrobe (addrStrobe),
    .strb       (strb)
  );

  otp_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .addrIn    (addrIn),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn)
  );

endmodule

// File: tb/otp_latched_rom_test.sv
`timescale 1ns/100ps
module otp_latched_rom_test;

  localparam int AW = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chipEnN = 1'b1, outEnN = 1'b1, progVolt = 1'b0, sigMode = 1'b0;
  logic          addrStrobe = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          dataOutEn;

  always #2 clk = ~clk;  // 250 MHz

  otp_latched_rom #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .chipEnN(chipEnN), .outEnN(outEnN),
    .progVolt(progVolt), .sigMode(sigMode), .addrStrobe(addrStrobe),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  typedef struct {
    logic          en;
    logic [DW-1:0] data;
    string         tag;
  } expItem_t;

  expItem_t      sbQueue[$];
  logic [DW-1:0] model [1 << AW];
  int            checks = 0;
  int            errors = 0;
  bit            done   = 0;

  // Monitor: compare one queued expectation per cycle, mid-cycle
  always @(negedge clk) begin
    if (sbQueue.size() != 0) begin
      expItem_t it;
      it = sbQueue.pop_front();
      checks++;
      if (dataOutEn !== it.en || (it.en && dataOut !== it.data) ||
          (!it.en && dataOut !== '0)) begin
        errors++;
        $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h",
                 it.tag, dataOutEn, dataOut, it.en, it.en ? it.data : '0);
      end
    end
  end

  task automatic cyc(input logic ce, oe, pv, sg, stb,
                     input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic eEn, input logic [DW-1:0] eData, input string tag);
    @(posedge clk); #1;
    chipEnN = ce; outEnN = oe; progVolt = pv; sigMode = sg;
    addrStrobe = stb; addrIn = a; dataIn = d;
    sbQueue.push_back('{eEn, eData, tag});
  endtask

  task automatic readAt(input logic [AW-1:0] a, input string tag);
    cyc(0, 0, 0, 0, 1, a, '0, 1'b1, model[a], tag);
  endtask

  task automatic verifyAt(input logic [AW-1:0] a, input string tag);
    cyc(1, 0, 1, 0, 1, a, '0, 1'b1, model[a], tag);
  endtask

  task automatic programAt(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input string tag);
    cyc(0, 1, 1, 0, 1, a, d, 1'b0, '0, tag);
    cyc(1, 1, 1, 0, 1, a, d, 1'b0, '0, tag);
    model[a] = model[a] & d;
  endtask

  initial begin
    #40000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: en=%0b data=%h expected run to finish", dataOutEn, dataOut);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = '1;
    repeat (3) @(posedge clk);
    sbQueue.push_back('{1'b0, '0, "R5 reset standby"});
    @(posedge clk); #1; rst = 1'b0;

    // R1: erased after reset
    readAt(0, "R1 erased low");
    readAt(AW'((1 << AW) - 1), "R1 erased top");

    // R6 and R7: program then verify, AND behaviour
    programAt(5, 8'hA5, "R6 program");
    verifyAt(5, "R7 verify A5");
    programAt(5, 8'h0F, "R6 and with 0F");
    verifyAt(5, "R7 verify 05");
    programAt(5, 8'hFF, "R6 ones cannot set");
    readAt(5, "R3 read after ones");

    // R2: latch holds while strobe low
    cyc(0, 0, 0, 0, 1, 7, '0, 1'b1, model[7], "R2 transparent");
    cyc(0, 0, 0, 0, 0, 5, '0, 1'b1, model[7], "R2 held address");
    cyc(0, 0, 0, 0, 0, 5, '0, 1'b1, model[7], "R2 still held");

    // R2 and R6: program through the held address
    cyc(1, 1, 1, 0, 1, 9, '0, 1'b0, '0, "R8 inhibit latch 9");
    cyc(0, 1, 1, 0, 0, 3, 8'h3C, 1'b0, '0, "R6 latched program");
    cyc(1, 1, 1, 0, 0, 3, 8'h3C, 1'b0, '0, "R6 latched commit");
    model[9] = model[9] & 8'h3C;
    verifyAt(9, "R2 held address written");
    verifyAt(3, "R2 applied address untouched");

    // R4 and R5
    cyc(0, 1, 0, 0, 1, 5, '0, 1'b0, '0, "R4 output disable");
    cyc(1, 0, 0, 0, 1, 5, '0, 1'b0, '0, "R5 standby oe low");
    cyc(1, 1, 0, 0, 1, 5, '0, 1'b0, '0, "R5 standby oe high");

    // R8: both enables low with program flag, then rising ce: no write
    cyc(0, 0, 1, 0, 1, 20, 8'h00, 1'b0, '0, "R8 both low no drive");
    cyc(1, 1, 1, 0, 1, 20, 8'h00, 1'b0, '0, "R8 inhibit");
    verifyAt(20, "R8 no write");

    // R10: program flag dropped at the rising edge: no write
    cyc(0, 1, 1, 0, 1, 21, 8'h00, 1'b0, '0, "R10 pulse");
    cyc(1, 1, 0, 0, 1, 21, 8'h00, 1'b0, '0, "R10 flag off at rise");
    readAt(21, "R10 no write");

    // R9: identifier codes, applied address used with strobe low
    cyc(0, 0, 0, 1, 0, 0, '0, 1'b1, 8'h20, "R9 even id");
    cyc(0, 0, 0, 1, 0, 1, '0, 1'b1, 8'h80, "R9 odd id");
    cyc(0, 0, 0, 1, 1, 2, '0, 1'b1, 8'h20, "R9 even id open latch");

    // Overlap: commit cycle is also a verify cycle
    cyc(0, 1, 1, 0, 1, 12, 8'h81, 1'b0, '0, "R6 overlap pulse");
    cyc(1, 0, 1, 0, 1, 12, 8'h81, 1'b1, model[12], "R7 old word in commit cycle");
    model[12] = model[12] & 8'h81;
    verifyAt(12, "R6 new word after commit");

    cyc(1, 1, 0, 0, 1, 0, '0, 1'b0, '0, "R5 final standby");
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule